// File: doc/BRIEF.md
# Serial-In Latched Parallel Driver Core

This block is the digital core of a multi-channel display or peripheral driver. A chain of register stages takes in one serial bit on each rising transition of a shift-clock input. A bank of per-channel hold cells copies the chain onto the parallel outputs while a load input is high. A blanking input turns every output off. The last stage of the chain is also driven out as a serial output, so several blocks can be chained into one longer string of channels.

All control inputs are synchronous to a faster system clock. The shift clock is edge-detected against its value in the previous system cycle. The hold cells are transparent: while the load input is high, each output follows its register stage in the same system cycle, and a held value keeps changing for as long as load stays high. When load falls, the value present at the last system clock edge with load high is kept. Blanking only gates the outputs and never alters what the hold cells store.

Top module: `serial_latch_drv`

## Requirements
- R1: After synchronous active-low reset, every register stage, every hold cell, every parallel output and the serial output are 0.
- R2: The chain shifts exactly once per low-to-high transition of `shift_clk_i`, as sampled on two consecutive system clock edges. The shift takes effect at the system clock edge that samples the high level. Holding `shift_clk_i` high, its falling edge, and changes on `ser_din_i` while no transition occurs all leave the chain unchanged.
- R3: On each shift, stage 1 takes `ser_din_i`, and every stage k>1 takes the old value of stage k-1. `ser_dout_o` is stage NUM_CH and changes on the same system edge as the shift. After NUM_CH shifts, the first bit shifted in appears on `ser_dout_o`.
- R4: While `load_i` is high, each hold cell is transparent: its output equals its stage in the same cycle, and it tracks every further shift for as long as `load_i` stays high.
- R5: While `load_i` is low, the hold cells keep their contents regardless of shifting.
- R6: While `blank_i` is high, all `drv_o` bits are 0, and the hold cell contents are not changed. When `blank_i` falls, the held values appear again.
- R7: While `blank_i` is low, `drv_o[i]` equals hold cell i, which loads from stage i+1. If a word P is shifted in most significant bit first and then loaded, the result is `drv_o == P`.
- R8: The channel count NUM_CH is a parameter (default 32, at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk_i | input | 1 | Shift clock; a low-to-high transition shifts the chain |
| ser_din_i | input | 1 | Serial data into stage 1 |
| load_i | input | 1 | High makes the hold cells transparent; low holds them |
| blank_i | input | 1 | High forces all parallel outputs to 0 |
| drv_o | output | NUM_CH | Parallel channel outputs, bit i is channel i |
| ser_dout_o | output | 1 | Last chain stage, used for cascading |

## Verification
A wrong value in a chain stage shows up on `ser_dout_o` within NUM_CH further shifts. If `load_i` is high, it also shows on the matching `drv_o` bit in the same cycle. A corrupted hold cell becomes visible on `drv_o` as soon as blanking is low. It is hidden while blanking is high and must reappear unchanged when blanking falls. The bench therefore sweeps every word of a small configuration through shift, load, blank and unblank. During every shift it also follows the serial output against a model of the chain.

// File: rtl/sld_pkg.sv
// Package: shared types and defaults for the serial-in latched driver core.
// Assumes all users compile this package first.
package sld_pkg;

    // Default number of output channels.
    localparam int SLD_DEFAULT_CH = 32;

    // One shift request from the edge detector to the register chain.
    typedef struct packed {
        logic pulse;   // high for one system cycle per shift-clock rise
        logic bit_in;  // serial bit to enter stage 1
    } shift_cmd_t;

endpackage

// File: rtl/sld_edge_detect.sv
// Module: sld_edge_detect
// Turns the sampled shift-clock level into a one-cycle shift request.
// Assumes shift_clk_i and ser_din_i are synchronous to clk. The stored level
// resets to 1, so a shift clock held high through reset does not count as a rise.
module sld_edge_detect
    import sld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_clk_i,
    input  logic       ser_din_i,
    output shift_cmd_t cmd_o
);

    logic sclk_prev_q;

    // Remember the shift-clock level from the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b1;
        else        sclk_prev_q <= shift_clk_i;
    end

    // Rise = high now and low last cycle; pass the data bit along.
    always_comb begin
        cmd_o.pulse  = shift_clk_i & ~sclk_prev_q;
        cmd_o.bit_in = ser_din_i;
    end

    // A request cannot repeat on back-to-back cycles without a low level between.
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o.pulse |=> !cmd_o.pulse) else $error("back-to-back shift"); // R2

endmodule

// File: rtl/sld_shift_chain.sv
// Module: sld_shift_chain
// Serial-in register chain. On each shift request, stage 1 (index 0) takes the
// serial bit and each later stage takes its predecessor.
// The last stage drives the serial output. Assumes NUM_CH >= 2.
module sld_shift_chain
    import sld_pkg::*;
#(
    parameter int NUM_CH = SLD_DEFAULT_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shift_cmd_t        cmd_i,
    output logic [NUM_CH-1:0] stages_o,
    output logic              sout_o
);

    localparam int LAST = NUM_CH - 1;

    logic [NUM_CH-1:0] stage_q;

    // Stage 1 loads the serial bit on a shift request.
    always_ff @(posedge clk) begin
        if (!rst_n)           stage_q[0] <= 1'b0;
        else if (cmd_i.pulse) stage_q[0] <= cmd_i.bit_in;
    end

    // Later stages each take the previous stage on a shift request.
    for (genvar k = 1; k < NUM_CH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)           stage_q[k] <= 1'b0;
            else if (cmd_i.pulse) stage_q[k] <= stage_q[k-1];
        end
    end

    assign stages_o = stage_q;
    assign sout_o   = stage_q[LAST];

    AST_ENTRY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.pulse |=> stage_q[0] == $past(cmd_i.bit_in)) else $error("entry"); // R3
    AST_TAIL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.pulse |=> sout_o == $past(stage_q[LAST-1])) else $error("tail"); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_i.pulse |=> $stable(stage_q)) else $error("idle shift"); // R2

endmodule

// File: rtl/sld_latch_bank.sv
// Module: sld_latch_bank
// Per-channel level-sensitive hold cells, built as a flop plus a bypass mux so
// the design stays synchronous. While load is high, each output is its input in
// the same cycle. While load is low, it is the value captured at the last system
// edge with load high.
module sld_latch_bank #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NUM_CH-1:0] d_i,
    output logic [NUM_CH-1:0] q_o
);

    logic [NUM_CH-1:0] held_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
        // Capture the channel input on every edge while load is high.
        always_ff @(posedge clk) begin
            if (!rst_n)      held_q[c] <= 1'b0;
            else if (load_i) held_q[c] <= d_i[c];
        end
        // Transparent while load is high, holding otherwise.
        assign q_o[c] = load_i ? d_i[c] : held_q[c];
    end

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(held_q)) else $error("hold lost"); // R5
    AST_CAPTURE_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> held_q == $past(d_i)) else $error("capture"); // R4

endmodule

// File: rtl/sld_out_gate.sv
// Module: sld_out_gate
// Blanking gate per channel. Forces each output off while blank is high and
// passes the hold-cell value otherwise. Has no storage of its own.
module sld_out_gate #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_i,
    input  logic              load_i,
    input  logic [NUM_CH-1:0] lat_i,
    output logic [NUM_CH-1:0] out_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
        // Off while blanked, else follow the hold cell.
        assign out_o[c] = lat_i[c] & ~blank_i;
    end

    // On unblanking with the cells closed throughout, the held word returns.
    AST_UNBLANK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(blank_i) && !load_i && $past(!load_i)) |-> out_o == $past(lat_i))
        else $error("unblank"); // R6

endmodule

// File: rtl/serial_latch_drv.sv
// Module: serial_latch_drv (top)
// Serial-in, latched, blankable parallel driver core with a cascade output.
// Assumes every input is synchronous to clk. NUM_CH >= 2.
module serial_latch_drv
    import sld_pkg::*;
#(
    parameter int NUM_CH = SLD_DEFAULT_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk_i,
    input  logic              ser_din_i,
    input  logic              load_i,
    input  logic              blank_i,
    output logic [NUM_CH-1:0] drv_o,
    output logic              ser_dout_o
);

    shift_cmd_t        cmd;
    logic [NUM_CH-1:0] stages;
    logic [NUM_CH-1:0] held;

    sld_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_clk_i (shift_clk_i),
        .ser_din_i   (ser_din_i),
        .cmd_o       (cmd)
    );

    sld_shift_chain #(.NUM_CH(NUM_CH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .stages_o (stages),
        .sout_o   (ser_dout_o)
    );

    sld_latch_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .d_i    (stages),
        .q_o    (held)
    );

    sld_out_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank_i (blank_i),
        .load_i  (load_i),
        .lat_i   (held),
        .out_o   (drv_o)
    );

    // Blanking must reach every output in the same cycle.
    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> drv_o == '0) else $error("blank leak"); // R6

endmodule

// File: tb/serial_latch_drv_test.sv
`timescale 1ns/100ps
// Bench: sweeps every word of an 8-channel configuration through shift, load,
// blank and unblank, and checks the serial output on every shift.
module serial_latch_drv_test;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n, sclk, din, load, blank;
    logic [N-1:0] drv;
    logic sout;

    always #2.5 clk = ~clk;

    serial_latch_drv #(.NUM_CH(N)) uut (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(sclk), .ser_din_i(din),
        .load_i(load), .blank_i(blank), .drv_o(drv), .ser_dout_o(sout)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [N-1:0] m_sr;   // expected chain contents, stage 1 at bit 0
    logic [N-1:0] m_lat;  // expected hold cells

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One full shift-clock pulse; returns just after a falling system edge.
    task automatic shift_bit(input logic b);
        @(negedge clk); din = b; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0; din = ~b;
        m_sr = {m_sr[N-2:0], b};
        if (load) m_lat = m_sr;
        #1;
    endtask

    // Open the hold cells across one system edge, then close them.
    task automatic load_pulse();
        @(negedge clk); load = 1'b1; m_lat = m_sr;
        @(negedge clk); load = 1'b0;
        #1;
    endtask

    function automatic logic [N-1:0] exp_out();
        return blank ? '0 : m_lat;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; din = 1'b0; load = 1'b0; blank = 1'b0;
        m_sr = '0; m_lat = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports, also with the cells opened
        check_vec("R1 drv after reset", drv, '0);
        check_bit("R1 sout after reset", sout, 1'b0);
        @(negedge clk); load = 1'b1; #1;
        check_vec("R1 chain zero via transparent cells", drv, '0);
        @(negedge clk); load = 1'b0; #1;

        // R2: shift clock held high shifts exactly once; data changes ignored
        @(negedge clk); din = 1'b1; sclk = 1'b1;
        repeat (3) @(negedge clk);
        din = 1'b0;
        @(negedge clk); sclk = 1'b0;
        repeat (2) @(negedge clk);
        m_sr = 8'h01;
        load = 1'b1; #1;
        check_vec("R2 single shift on long high", drv, 8'h01);
        @(negedge clk); load = 1'b0; m_lat = m_sr;
        // R2: data toggling with shift clock low changes nothing
        repeat (4) begin @(negedge clk); din = ~din; end
        load = 1'b1; #1;
        check_vec("R2 no shift without rise", drv, 8'h01);
        @(negedge clk); load = 1'b0; #1;

        // R4: transparent tracking during shifts with load held high
        @(negedge clk); load = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            logic [N-1:0] w;
            w = 8'hA5;
            shift_bit(w[i]);
            check_vec("R4 transparent tracking", drv, m_sr);
        end
        check_vec("R4 word after tracking", drv, 8'hA5);
        @(negedge clk); load = 1'b0; m_lat = m_sr; #1;

        // R3/R5/R6/R7: exhaustive word sweep
        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] pv;
            logic [N-1:0] prev;
            pv = p[N-1:0];
            prev = m_sr;
            for (int i = N - 1; i >= 0; i--) begin
                shift_bit(pv[i]);
                // R3: after k shifts stage N holds old stage N-k, then new bits
                if (i > 0) check_bit("R3 cascade out during shift", sout, prev[i-1]);
                else       check_bit("R3 first bit reaches serial out", sout, pv[N-1]);
            end
            check_vec("R5 outputs held while shifting", drv, exp_out());
            load_pulse();
            check_vec("R7 channel i equals word bit i", drv, pv);
            if (p % 16 == 3) begin
                @(negedge clk); blank = 1'b1; #1;
                check_vec("R6 blank forces off", drv, '0);
                load_pulse();
                check_vec("R6 blank with load pulse", drv, '0);
                @(negedge clk); blank = 1'b0; #1;
                check_vec("R6 unblank restores word", drv, pv);
            end
        end

        // R8: full width channel count exercised through all 8 bits above
        check_vec("R8 final word", drv, 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule